// File: doc/BRIEF.md
# Front-End Configuration Register Bank with SPI Access

This block is the slow-control endpoint of a 64-channel detector readout chip. An external controller reaches 28 byte-wide registers through a four-wire serial link in SPI mode 0. The writable registers drive the analog front end as parallel outputs: the per-channel hit masks, four threshold DAC codes (one for each group of 16 channels), a single monostable stretch code shared by all channels, the test-pulse setup and a control word. Two read-only regions carry ADC readback bytes and test-pulse result bytes. Their values come straight from status inputs and are sampled when a read command is decoded.

The serial pins are synchronized into a system clock that runs at least eight times faster than the serial clock (nominally 1 MHz). Every access is framed by chip select. It consists of one command byte followed by one data byte, both sent MSB first and sampled on the rising serial clock edge. The bank drives read data onto MISO, changing it after falling edges.

Top module: `spi_cfg_bank`

## Requirements
- R1: After reset, every writable register (and so every configuration output) is 0 and MISO is 0.
- R2: A frame of 16 serial bits whose command bit 7 is 1 writes the second byte to the register at command bits 4:0. The write also completes when chip select rises one system clock after the 16th rising serial clock edge.
- R3: When command bit 7 is 0, the addressed register's value is shifted out on MISO during the second byte, MSB first. Each bit is valid at the rising serial clock edge.
- R4: Addresses 0 to 7 are the mask registers. Address n drives mask_o bits 8n+7 down to 8n.
- R5: Addresses 8 to 11 drive thr_o bytes 0 to 3. Address 12 drives pw_o, address 18 drives tcfg_o and address 27 drives ctrl_o.
- R6: A read of addresses 13 to 17 returns adc_i byte (address minus 13). A read of addresses 19 to 26 returns tres_i byte (address minus 19). Both are sampled when the command byte completes.
- R7: Writes to addresses 13 to 17, 19 to 26 and 28 to 31 change no output. A read of addresses 28 to 31 returns 0.
- R8: MISO is 0 whenever chip select (cs_ni) is high.
- R9: A frame cut off by chip select before its 16th bit writes nothing. The next frame starts again at bit 0.
- R10: Command bits 6 and 5 have no effect on reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock, idle low |
| mosi_i | input | 1 | Serial data in |
| cs_ni | input | 1 | Chip select, active low |
| miso_o | output | 1 | Serial data out |
| adc_i | input | 40 | Five ADC readback bytes |
| tres_i | input | 64 | Eight test-pulse result bytes |
| mask_o | output | 64 | Channel mask bits, one per channel |
| thr_o | output | 32 | Four threshold DAC codes |
| pw_o | output | 8 | Monostable stretch code |
| tcfg_o | output | 8 | Test-pulse configuration |
| ctrl_o | output | 8 | Control word |

## Verification
Two events can land in the same system clock cycle: the commit of a write on the last synchronized serial edge, and the release of the frame by chip select. The bench provokes this by raising chip select one system clock after the 16th rising edge, while the serial clock is still high. It then judges the result from the configuration outputs and from a later read of the same address. Random frames mix reads and writes over all 32 addresses, random values in the unused command bits, truncated frames and status inputs that change between frames. A bench model of the map predicts every output and every read byte.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ADDR_W = 5;

  localparam int unsigned N_MASK = 8;
  localparam int unsigned N_THR  = 4;
  localparam int unsigned N_PW   = 1;
  localparam int unsigned N_ADC  = 5;
  localparam int unsigned N_TCFG = 1;
  localparam int unsigned N_TRES = 8;
  localparam int unsigned N_CTRL = 1;

  localparam int unsigned A_MASK = 0;
  localparam int unsigned A_THR  = A_MASK + N_MASK;
  localparam int unsigned A_PW   = A_THR + N_THR;
  localparam int unsigned A_ADC  = A_PW + N_PW;
  localparam int unsigned A_TCFG = A_ADC + N_ADC;
  localparam int unsigned A_TRES = A_TCFG + N_TCFG;
  localparam int unsigned A_CTRL = A_TRES + N_TRES;
  localparam int unsigned N_REGS = A_CTRL + N_CTRL;

  localparam int unsigned FRAME_BITS = 2 * REG_W;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int unsigned CFG_W      = (N_MASK + N_THR + N_PW + N_TCFG + N_CTRL) * REG_W;

  typedef enum logic [1:0] {
    REG_CFG,
    REG_ADC,
    REG_TRES,
    REG_NONE
  } reg_kind_e;

  function automatic reg_kind_e reg_kind(int unsigned a);
    if (a >= A_ADC && a < A_ADC + N_ADC)    return REG_ADC;
    if (a >= A_TRES && a < A_TRES + N_TRES) return REG_TRES;
    if (a < N_REGS)                         return REG_CFG;
    return REG_NONE;
  endfunction
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int unsigned   W       = 3,
  parameter int unsigned   STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] pipe_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= {(STAGES + 1){RST_VAL[gi]}};
      else         pipe_q <= {pipe_q[STAGES-1:0], d_i[gi]};
    end
    assign lvl_o[gi]  = pipe_q[STAGES-1];
    assign rise_o[gi] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o[gi] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
  end
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              mosi_i,
  input  logic              cs_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [REG_W-1:0]  wr_data_o,
  output logic              tx_bit_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(REG_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_1ST  = CNT_W'(REG_W);
  localparam logic [CNT_W-1:0] FULL      = CNT_W'(FRAME_BITS);

  logic [REG_W-2:0]  rx_q;
  logic [REG_W-1:0]  byte_w;
  logic [CNT_W-1:0]  cnt_q;
  logic              is_wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [REG_W-1:0]  tx_q;
  logic              rd_act_q;
  logic              wr_stb_q;
  logic [REG_W-1:0]  wr_data_q;
  logic              take_bit;

  assign byte_w    = {rx_q, mosi_i};
  assign rd_addr_o = byte_w[ADDR_W-1:0];  // look-ahead on the last command bit
  assign take_bit  = sck_rise_i && (cnt_q < FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      cnt_q     <= '0;
      is_wr_q   <= 1'b0;
      addr_q    <= '0;
      tx_q      <= '0;
      rd_act_q  <= 1'b0;
      wr_stb_q  <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_stb_q <= 1'b0;
      if (cs_i) begin
        cnt_q    <= '0;
        rd_act_q <= 1'b0;
        tx_q     <= '0;
      end else if (take_bit) begin
        cnt_q <= cnt_q + 1'b1;
        rx_q  <= byte_w[REG_W-2:0];
        if (cnt_q == CMD_LAST) begin
          is_wr_q  <= byte_w[REG_W-1];
          addr_q   <= byte_w[ADDR_W-1:0];
          rd_act_q <= ~byte_w[REG_W-1];
          tx_q     <= rd_data_i;
        end
        if (cnt_q == DATA_LAST && is_wr_q) begin
          wr_stb_q  <= 1'b1;
          wr_data_q <= byte_w;
        end
      end else if (sck_fall_i && rd_act_q && cnt_q > DATA_1ST && cnt_q < FULL) begin
        // MSB is held through the first data edge; later falls advance
        tx_q <= {tx_q[REG_W-2:0], 1'b0};
      end
    end
  end

  assign wr_stb_o  = wr_stb_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = wr_data_q;
  assign tx_bit_o  = rd_act_q & tx_q[REG_W-1];
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import spi_cfg_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_stb_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [REG_W-1:0]          wr_data_i,
  input  logic [ADDR_W-1:0]         rd_addr_i,
  input  logic [N_ADC*REG_W-1:0]    adc_i,
  input  logic [N_TRES*REG_W-1:0]   tres_i,
  output logic [REG_W-1:0]          rd_data_o,
  output logic [N_MASK*REG_W-1:0]   mask_o,
  output logic [N_THR*REG_W-1:0]    thr_o,
  output logic [N_PW*REG_W-1:0]     pw_o,
  output logic [N_TCFG*REG_W-1:0]   tcfg_o,
  output logic [N_CTRL*REG_W-1:0]   ctrl_o
);
  logic [N_REGS*REG_W-1:0] view;

  for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
    if (reg_kind(gi) == REG_CFG) begin : g_cfg
      logic [REG_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                        q <= '0;
        else if (wr_stb_i && wr_addr_i == ADDR_W'(gi))      q <= wr_data_i;
      end
      assign view[gi*REG_W +: REG_W] = q;
    end else if (reg_kind(gi) == REG_ADC) begin : g_adc
      assign view[gi*REG_W +: REG_W] = adc_i[(gi - A_ADC)*REG_W +: REG_W];
    end else begin : g_tres
      assign view[gi*REG_W +: REG_W] = tres_i[(gi - A_TRES)*REG_W +: REG_W];
    end
  end

  assign rd_data_o = (rd_addr_i < ADDR_W'(N_REGS)) ? view[rd_addr_i*REG_W +: REG_W] : '0;

  assign mask_o = view[A_MASK*REG_W +: N_MASK*REG_W];
  assign thr_o  = view[A_THR*REG_W  +: N_THR*REG_W];
  assign pw_o   = view[A_PW*REG_W   +: N_PW*REG_W];
  assign tcfg_o = view[A_TCFG*REG_W +: N_TCFG*REG_W];
  assign ctrl_o = view[A_CTRL*REG_W +: N_CTRL*REG_W];
endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sck_i,
  input  logic                     mosi_i,
  input  logic                     cs_ni,
  output logic                     miso_o,
  input  logic [N_ADC*REG_W-1:0]   adc_i,
  input  logic [N_TRES*REG_W-1:0]  tres_i,
  output logic [N_MASK*REG_W-1:0]  mask_o,
  output logic [N_THR*REG_W-1:0]   thr_o,
  output logic [N_PW*REG_W-1:0]    pw_o,
  output logic [N_TCFG*REG_W-1:0]  tcfg_o,
  output logic [N_CTRL*REG_W-1:0]  ctrl_o
);
  logic [2:0]        s_lvl, s_rise, s_fall;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [REG_W-1:0]  rd_data, wr_data;
  logic              wr_stb, tx_bit;
  logic [CNT_W-1:0]  bit_cnt;

  // bit 0 sck, bit 1 mosi, bit 2 chip select (idles high)
  spi_sync_edge #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_ni, mosi_i, sck_i}),
    .lvl_o  (s_lvl),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  spi_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sck_rise_i (s_rise[0]),
    .sck_fall_i (s_fall[0]),
    .mosi_i     (s_lvl[1]),
    .cs_i       (s_lvl[2]),
    .rd_data_i  (rd_data),
    .rd_addr_o  (rd_addr),
    .wr_stb_o   (wr_stb),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .tx_bit_o   (tx_bit),
    .cnt_o      (bit_cnt)
  );

  cfg_regfile u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stb_i  (wr_stb),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .adc_i     (adc_i),
    .tres_i    (tres_i),
    .rd_data_o (rd_data),
    .mask_o    (mask_o),
    .thr_o     (thr_o),
    .pw_o      (pw_o),
    .tcfg_o    (tcfg_o),
    .ctrl_o    (ctrl_o)
  );

  // raw select gates the pin so it idles low without synchronizer delay
  assign miso_o = ~cs_ni & tx_bit;
endmodule

// File: rtl/spi_cfg_bank_chk.sv
module spi_cfg_bank_chk
  import spi_cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              miso_o,
  input logic              cs_s,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [CFG_W-1:0]  cfg_i
);
  // R8
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !miso_o);

  // R7
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb && reg_kind(int'(wr_addr)) != REG_CFG) |=> $stable(cfg_i));

  // R9
  no_strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb |=> $stable(cfg_i));

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(FRAME_BITS));

  // R9
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> bit_cnt == '0);

  // R1
  reset_val_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (cfg_i == '0 && !miso_o));
endmodule

bind spi_cfg_bank spi_cfg_bank_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .miso_o  (miso_o),
  .cs_s    (s_lvl[2]),
  .wr_stb  (wr_stb),
  .wr_addr (wr_addr),
  .bit_cnt (bit_cnt),
  .cfg_i   ({mask_o, thr_o, pw_o, tcfg_o, ctrl_o})
);

// File: tb/tb_spi_cfg_bank.sv
module tb_spi_cfg_bank;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck_i = 1'b0, mosi_i = 1'b0, cs_ni = 1'b1;
  logic miso_o;
  logic [39:0] adc_i = '0;
  logic [63:0] tres_i = '0;
  logic [63:0] mask_o;
  logic [31:0] thr_o;
  logic [7:0]  pw_o, tcfg_o, ctrl_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [0:27];

  always #2 clk = ~clk;

  spi_cfg_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck_i), .mosi_i(mosi_i), .cs_ni(cs_ni),
    .miso_o(miso_o), .adc_i(adc_i), .tres_i(tres_i), .mask_o(mask_o),
    .thr_o(thr_o), .pw_o(pw_o), .tcfg_o(tcfg_o), .ctrl_o(ctrl_o)
  );

  function automatic bit wr_ok(int a);
    return (a <= 12) || (a == 18) || (a == 27);
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    if (wr_ok(a))            return model[a];
    if (a >= 13 && a <= 17)  return adc_i[(a-13)*8 +: 8];
    if (a >= 19 && a <= 26)  return tres_i[(a-19)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic string tag_of(int a);
    if (a <= 7)                          return "R4";
    if (wr_ok(a))                        return "R5";
    if (a <= 26)                         return "R6";
    return "R7";
  endfunction

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_cfg(string req);
    logic [119:0] exp;
    for (int i = 0; i < 8; i++) exp[56 + i*8 +: 8] = model[i];
    for (int i = 0; i < 4; i++) exp[24 + i*8 +: 8] = model[8+i];
    exp[16 +: 8] = model[12];
    exp[8 +: 8]  = model[18];
    exp[0 +: 8]  = model[27];
    chk({mask_o, thr_o, pw_o, tcfg_o, ctrl_o} == exp, req,
        {mask_o, thr_o, pw_o, tcfg_o, ctrl_o}, exp);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int nbits,
                      input bit late, output logic [7:0] rx);
    logic [15:0] fr;
    fr = {cmd, dat};
    rx = '0;
    cs_ni = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi_i = fr[15-i];
      wait_clk(HALF);
      if (i >= 8) rx = {rx[6:0], miso_o};
      sck_i = 1'b1;
      if (late && i == nbits - 1) begin
        wait_clk(1);
        cs_ni = 1'b1;
      end
      wait_clk(HALF);
      sck_i = 1'b0;
    end
    wait_clk(HALF);
    cs_ni  = 1'b1;
    mosi_i = 1'b0;
    wait_clk(8);
  endtask

  task automatic op(logic [7:0] cmd, logic [7:0] dat, int nbits, bit late, string tag);
    logic [7:0] rx;
    int a;
    string t;
    a = int'(cmd[4:0]);
    xfer(cmd, dat, nbits, late, rx);
    if (nbits == 16 && cmd[7] && wr_ok(a)) model[a] = dat;
    t = (tag != "") ? tag : (nbits < 16) ? "R9" : (cmd[7] && !wr_ok(a)) ? "R7" : tag_of(a);
    if (nbits == 16 && !cmd[7])
      chk(rx == exp_rd(a), (tag != "") ? tag : "R3", rx, exp_rd(a));
    check_cfg(t);
    chk(miso_o == 1'b0, "R8", miso_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] cmd;
    int nb;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 28; i++) model[i] = 8'h00;
    wait_clk(5);
    // R1: reset state
    check_cfg("R1");
    chk(miso_o == 1'b0, "R1", miso_o, 0);
    rst_ni = 1'b1;
    wait_clk(4);
    check_cfg("R1");
    op(8'h00 | 8'd27, 8'h00, 16, 0, "R1");

    // R4/R5: write every writable address, then read all 32
    for (int a = 0; a < 28; a++)
      if (wr_ok(a)) op(8'h80 | 8'(a), 8'(8'h3C ^ (a * 37)), 16, 0, tag_of(a));
    adc_i  = 40'hA1B2C3D4E5;
    tres_i = 64'h0123456789ABCDEF;
    for (int a = 0; a < 32; a++) op(8'(a), 8'h00, 16, 0, tag_of(a));

    // R7: writes to read-only and unmapped addresses
    op(8'h80 | 8'd15, 8'hFF, 16, 0, "R7");
    op(8'h80 | 8'd22, 8'hFF, 16, 0, "R7");
    op(8'h80 | 8'd30, 8'hFF, 16, 0, "R7");
    op(8'd15, 8'h00, 16, 0, "R7");
    op(8'd30, 8'h00, 16, 0, "R7");

    // R9: truncated write, then a fresh full frame
    op(8'h80, 8'h5A, 15, 0, "R9");
    op(8'h80 | 8'd3, 8'h11, 9, 0, "R9");
    op(8'h00, 8'h00, 16, 0, "R9");

    // R10: command bits 6:5 ignored
    op(8'hE0 | 8'd27, 8'h96, 16, 0, "R10");
    op(8'h20 | 8'd27, 8'h00, 16, 0, "R10");
    op(8'h40 | 8'd9, 8'h00, 16, 0, "R10");

    // R2: chip select rises right after the 16th rising edge
    op(8'h80 | 8'd12, 8'hC3, 16, 1, "R2");
    op(8'd12, 8'h00, 16, 0, "R2");

    // random mix
    for (int n = 0; n < 220; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        adc_i  = {$urandom(), 8'($urandom())};
        tres_i = {$urandom(), $urandom()};
      end
      cmd = 8'($urandom());
      nb  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 15)) : 16;
      op(cmd, 8'($urandom()), nb, ($urandom_range(0, 7) == 0), "");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule